// File: doc/BRIEF.md
# Calibration Coefficient Averaging Engine

This engine runs on the host side of a dual-core current-output DAC. It moves the 32 six-bit trim coefficients of one core (I or Q) across a generic register-access port. Each coefficient access is indirect. The engine writes the coefficient address to an address register and sets a memory-read or memory-write mode bit. It then moves the value through a data register and finally drops the mode bit.

A separate sequencer starts the device's self-calibration runs. After each run finishes, that sequencer issues a read-accumulate command. The engine then reads every coefficient and adds its low six bits into a saturating per-coefficient sum. Once the chosen number of runs has been collected, a write-back command stores the rounded average of every coefficient back into the selected core. This gives a trim that is less noisy than the result of any single run. A clear command resets the sums. A debug port shows the average of any coefficient at any time.

The register port is a valid/ready request channel. The engine raises `req_valid` with `req_wr`, `req_addr` and `req_wdata`, and holds all four unchanged until the port raises `req_ready`. A request completes in the cycle in which both signals are high, and the port may hold `req_ready` low for as long as it needs. For a read, `req_rdata` is taken in that completing cycle only. The command, select and debug pins are plain level or single-cycle signals.

Top module: `coef_avg_engine`

## Requirements
- R1: After reset, `busy`, `done` and `req_valid` are low, every sum is zero and write-back is not permitted.
- R2: A read-accumulate pass issues exactly 130 requests:
  - a write to 0x0E of 0x10 (core I, `core_sel`=0) or 0x20 (core Q, `core_sel`=1);
  - then, for coefficient k = 1 to 32 in order: write k to 0x10, write 0x04 to 0x12, read 0x11, write 0x00 to 0x12;
  - then a write of 0x00 to 0x0E.
- R3: On each accepted read of 0x11, only `req_rdata[5:0]` is added into the sum of coefficient k. Each sum is 11 bits and saturates at 2047.
- R4: A write-back pass issues exactly 99 requests:
  - the core-select write to 0x0E;
  - then, for k = 1 to 32 in order: write 0x08 to 0x12, write k to 0x10, write the average of coefficient k (bits 7:6 zero) to 0x11;
  - then write 0x00 to 0x12 and 0x00 to 0x0E.
- R5: The average is floor((sum + floor(n/2)) / n), where n is `run_count`, and it saturates to 63. A write-back uses the `run_count` captured when the command starts.
- R6: A write-back command is refused (no request, `busy` stays low, no `done`) when no read-accumulate pass has completed since reset or the last clear, or when `run_count` is 0.
- R7: A clear command zeroes all sums and withdraws the permission to write back.
- R8: While `busy` is high, all commands are ignored. They neither disturb the running pass nor change the sums.
- R9: While `req_valid` is high and `req_ready` is low, the request fields stay unchanged. Read data offered in cycles without acceptance has no effect.
- R10: `busy` rises in the cycle after an accepted command and falls in the cycle after the final 0x0E write is accepted. In that same cycle `done` pulses high for one cycle.
- R11: `dbg_avg` shows, combinationally, the average (as in R5, using the current `run_count`) of coefficient `dbg_idx`+1.
- R12: When several commands arrive in the same idle cycle, only one is taken: clear first, then read-accumulate, then write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_sel | input | 1 | 0 selects core I, 1 selects core Q; sampled with a command |
| run_count | input | 6 | Divisor for averaging (number of runs) |
| cmd_accum | input | 1 | Start a read-accumulate pass |
| cmd_wback | input | 1 | Start a write-back pass |
| cmd_clear | input | 1 | Clear sums and write-back permission |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register port accepts the request |
| req_wr | output | 1 | 1 = write, 0 = read |
| req_addr | output | 8 | Register address |
| req_wdata | output | 8 | Write data |
| req_rdata | input | 8 | Read data, taken on acceptance |
| dbg_idx | input | 5 | Coefficient index (address minus one) for debug |
| dbg_avg | output | 6 | Average of the selected coefficient |

## Verification
The bench builds the engine with its default parameters: 32 coefficients of 6 bits, a 6-bit run count and 11-bit sums. With these values, about forty accumulate passes of all-ones coefficients reach the saturation ceiling of a sum. A run count of 63 then shows that saturation in the average, and a run count of 1 shows the clamp of the average to 63. A register model with random back-pressure and random upper read bits exercises the hold rule and the rule that only six bits are kept. The same model checks every request of every pass against the expected order.

// File: rtl/coef_avg_pkg.sv
package coef_avg_pkg;

  // Device register map used by the indirect coefficient access
  localparam logic [7:0] RA_CORE_SEL  = 8'h0E;
  localparam logic [7:0] RA_COEF_ADDR = 8'h10;
  localparam logic [7:0] RA_COEF_DATA = 8'h11;
  localparam logic [7:0] RA_MODE      = 8'h12;

  localparam logic [7:0] MODE_IDLE    = 8'h00;
  localparam logic [7:0] MODE_MEM_RD  = 8'h04;
  localparam logic [7:0] MODE_MEM_WR  = 8'h08;
  localparam logic [7:0] SEL_CORE_I   = 8'h10;
  localparam logic [7:0] SEL_CORE_Q   = 8'h20;
  localparam logic [7:0] SEL_NONE     = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_RD_ADDR,
    ST_RD_MODE,
    ST_RD_DATA,
    ST_RD_CLR,
    ST_WR_MODE,
    ST_WR_ADDR,
    ST_WR_DATA,
    ST_WR_END,
    ST_DESEL
  } seq_st_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_CLEAR,
    OP_ACCUM,
    OP_WBACK
  } op_e;

endpackage

// File: rtl/coef_avg_div.sv
// Rounded (half-up) division of a coefficient sum by the run count,
// clamped to the coefficient range. A zero divisor yields zero.
module coef_avg_div #(
  parameter int SUM_W  = 11,
  parameter int RC_W   = 6,
  parameter int COEF_W = 6
) (
  input  logic [SUM_W-1:0]  sum,
  input  logic [RC_W-1:0]   divisor,
  output logic [COEF_W-1:0] avg
);

  localparam int NW = (SUM_W > RC_W ? SUM_W : RC_W) + 1;
  localparam logic [NW-1:0] COEF_MAX = NW'((1 << COEF_W) - 1);

  logic [NW-1:0] num;
  logic [NW-1:0] den;
  logic [NW-1:0] quo;

  always_comb begin
    den = NW'(divisor);
    num = NW'(sum) + NW'(divisor >> 1);
    quo = (den == '0) ? '0 : num / den;
    avg = (quo > COEF_MAX) ? COEF_MAX[COEF_W-1:0] : quo[COEF_W-1:0];
  end

endmodule

// File: rtl/coef_avg_sums.sv
// Per-coefficient saturating running sums with two read ports.
module coef_avg_sums #(
  parameter int NUM_COEF = 32,
  parameter int COEF_W   = 6,
  parameter int SUM_W    = 11,
  localparam int IDX_W   = $clog2(NUM_COEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_en,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [COEF_W-1:0] acc_val,
  input  logic [IDX_W-1:0]  rd_idx_a,
  output logic [SUM_W-1:0]  rd_sum_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [SUM_W-1:0]  rd_sum_b
);

  logic [SUM_W-1:0] sum_q [NUM_COEF];
  logic [SUM_W:0]   add_res;

  assign add_res = {1'b0, sum_q[acc_idx]} + (SUM_W + 1)'(acc_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_COEF; i++) sum_q[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NUM_COEF; i++) sum_q[i] <= '0;
    end else if (acc_en) begin
      sum_q[acc_idx] <= add_res[SUM_W] ? {SUM_W{1'b1}} : add_res[SUM_W-1:0];
    end
  end

  assign rd_sum_a = sum_q[rd_idx_a];
  assign rd_sum_b = sum_q[rd_idx_b];

endmodule

// File: rtl/coef_avg_seq.sv
// Pass sequencer: walks the indirect register protocol for a
// read-accumulate or write-back pass, one request at a time.
module coef_avg_seq
  import coef_avg_pkg::*;
#(
  parameter int NUM_COEF = 32,
  parameter int COEF_W   = 6,
  parameter int RC_W     = 6,
  parameter int REG_AW   = 8,
  parameter int REG_DW   = 8,
  localparam int IDX_W   = $clog2(NUM_COEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              core_sel,
  input  logic [RC_W-1:0]   run_count,
  input  logic [COEF_W-1:0] avg_in,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_wr,
  output logic [REG_AW-1:0] req_addr,
  output logic [REG_DW-1:0] req_wdata,
  output logic              acc_en,
  output logic [IDX_W-1:0]  idx,
  output logic [RC_W-1:0]   rc_hold,
  output logic              sum_clr,
  output logic              busy,
  output logic              done,
  output logic              wb_ok
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COEF - 1);

  seq_st_e           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic              core_q;
  logic              acc_mode_q;
  logic [RC_W-1:0]   rc_q;
  logic              wb_ok_q;
  logic              done_q;
  logic              ack;
  logic              last;
  logic [REG_AW-1:0] coef_addr;

  assign ack       = req_valid && req_ready;
  assign last      = (idx_q == LAST_IDX);
  assign coef_addr = REG_AW'(idx_q) + REG_AW'(1);

  // Request decode from the current state
  always_comb begin
    req_valid = 1'b1;
    req_wr    = 1'b1;
    req_addr  = '0;
    req_wdata = '0;
    unique case (st_q)
      ST_IDLE: req_valid = 1'b0;
      ST_SEL: begin
        req_addr  = REG_AW'(RA_CORE_SEL);
        req_wdata = core_q ? REG_DW'(SEL_CORE_Q) : REG_DW'(SEL_CORE_I);
      end
      ST_RD_ADDR, ST_WR_ADDR: begin
        req_addr  = REG_AW'(RA_COEF_ADDR);
        req_wdata = REG_DW'(coef_addr);
      end
      ST_RD_MODE: begin
        req_addr  = REG_AW'(RA_MODE);
        req_wdata = REG_DW'(MODE_MEM_RD);
      end
      ST_RD_DATA: begin
        req_wr   = 1'b0;
        req_addr = REG_AW'(RA_COEF_DATA);
      end
      ST_RD_CLR, ST_WR_END: begin
        req_addr  = REG_AW'(RA_MODE);
        req_wdata = REG_DW'(MODE_IDLE);
      end
      ST_WR_MODE: begin
        req_addr  = REG_AW'(RA_MODE);
        req_wdata = REG_DW'(MODE_MEM_WR);
      end
      ST_WR_DATA: begin
        req_addr  = REG_AW'(RA_COEF_DATA);
        req_wdata = REG_DW'(avg_in);
      end
      ST_DESEL: begin
        req_addr  = REG_AW'(RA_CORE_SEL);
        req_wdata = REG_DW'(SEL_NONE);
      end
      default: req_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      core_q     <= 1'b0;
      acc_mode_q <= 1'b0;
      rc_q       <= '0;
      wb_ok_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          unique case (op)
            OP_CLEAR: wb_ok_q <= 1'b0;
            OP_ACCUM: begin
              st_q       <= ST_SEL;
              acc_mode_q <= 1'b1;
              core_q     <= core_sel;
            end
            OP_WBACK: begin
              if (wb_ok_q && run_count != '0) begin
                st_q       <= ST_SEL;
                acc_mode_q <= 1'b0;
                core_q     <= core_sel;
                rc_q       <= run_count;
              end
            end
            default: ;
          endcase
        end
        ST_SEL: if (ack) begin
          idx_q <= '0;
          st_q  <= acc_mode_q ? ST_RD_ADDR : ST_WR_MODE;
        end
        ST_RD_ADDR: if (ack) st_q <= ST_RD_MODE;
        ST_RD_MODE: if (ack) st_q <= ST_RD_DATA;
        ST_RD_DATA: if (ack) st_q <= ST_RD_CLR;
        ST_RD_CLR: if (ack) begin
          if (last) st_q <= ST_DESEL;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_RD_ADDR;
          end
        end
        ST_WR_MODE: if (ack) st_q <= ST_WR_ADDR;
        ST_WR_ADDR: if (ack) st_q <= ST_WR_DATA;
        ST_WR_DATA: if (ack) begin
          if (last) st_q <= ST_WR_END;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_WR_MODE;
          end
        end
        ST_WR_END: if (ack) st_q <= ST_DESEL;
        ST_DESEL: if (ack) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          if (acc_mode_q) wb_ok_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_en  = (st_q == ST_RD_DATA) && ack;
  assign idx     = idx_q;
  assign rc_hold = rc_q;
  assign sum_clr = (st_q == ST_IDLE) && (op == OP_CLEAR);
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign wb_ok   = wb_ok_q;

endmodule

// File: rtl/coef_avg_engine.sv
module coef_avg_engine
  import coef_avg_pkg::*;
#(
  parameter int NUM_COEF = 32,
  parameter int COEF_W   = 6,
  parameter int MAX_RUNS = 32,
  parameter int REG_AW   = 8,
  parameter int REG_DW   = 8,
  localparam int IDX_W   = $clog2(NUM_COEF),
  localparam int RC_W    = $clog2(MAX_RUNS + 1),
  localparam int SUM_W   = COEF_W + $clog2(MAX_RUNS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_sel,
  input  logic [RC_W-1:0]   run_count,
  input  logic              cmd_accum,
  input  logic              cmd_wback,
  input  logic              cmd_clear,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_wr,
  output logic [REG_AW-1:0] req_addr,
  output logic [REG_DW-1:0] req_wdata,
  input  logic [REG_DW-1:0] req_rdata,
  input  logic [IDX_W-1:0]  dbg_idx,
  output logic [COEF_W-1:0] dbg_avg
);

  op_e              op;
  logic             acc_en;
  logic             sum_clr;
  logic             wb_ok;
  logic [IDX_W-1:0] seq_idx;
  logic [RC_W-1:0]  rc_hold;
  logic [SUM_W-1:0] sum_seq;
  logic [SUM_W-1:0] sum_dbg;
  logic [COEF_W-1:0] avg_seq;

  // One command per cycle: clear beats accumulate beats write-back
  always_comb begin
    if (cmd_clear)      op = OP_CLEAR;
    else if (cmd_accum) op = OP_ACCUM;
    else if (cmd_wback) op = OP_WBACK;
    else                op = OP_NONE;
  end

  coef_avg_seq #(
    .NUM_COEF(NUM_COEF), .COEF_W(COEF_W), .RC_W(RC_W),
    .REG_AW(REG_AW), .REG_DW(REG_DW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .op(op), .core_sel(core_sel),
    .run_count(run_count), .avg_in(avg_seq),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .acc_en(acc_en), .idx(seq_idx), .rc_hold(rc_hold),
    .sum_clr(sum_clr), .busy(busy), .done(done), .wb_ok(wb_ok)
  );

  coef_avg_sums #(
    .NUM_COEF(NUM_COEF), .COEF_W(COEF_W), .SUM_W(SUM_W)
  ) u_sums (
    .clk(clk), .rst_n(rst_n), .clr(sum_clr),
    .acc_en(acc_en), .acc_idx(seq_idx), .acc_val(req_rdata[COEF_W-1:0]),
    .rd_idx_a(seq_idx), .rd_sum_a(sum_seq),
    .rd_idx_b(dbg_idx), .rd_sum_b(sum_dbg)
  );

  coef_avg_div #(.SUM_W(SUM_W), .RC_W(RC_W), .COEF_W(COEF_W)) u_div_wb (
    .sum(sum_seq), .divisor(rc_hold), .avg(avg_seq)
  );

  coef_avg_div #(.SUM_W(SUM_W), .RC_W(RC_W), .COEF_W(COEF_W)) u_div_dbg (
    .sum(sum_dbg), .divisor(run_count), .avg(dbg_avg)
  );

endmodule

// File: rtl/coef_avg_engine_chk.sv
module coef_avg_engine_chk #(
  parameter int REG_AW = 8,
  parameter int REG_DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              cmd_accum,
  input logic              cmd_wback,
  input logic              cmd_clear,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_wr,
  input logic [REG_AW-1:0] req_addr,
  input logic [REG_DW-1:0] req_wdata,
  input logic              wb_ok
);

  // R9: a stalled request keeps its fields
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_wr) &&
      $stable(req_addr) && $stable(req_wdata));

  // R10: no register traffic while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done marks the end of a busy interval
  p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  // R6: write-back without collected data never starts
  p_refuse_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_wback && !cmd_accum && !cmd_clear && !wb_ok |=> !busy);

  // R12: clear wins over a simultaneous start
  p_clear_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_clear |=> !busy);

  // R8: a pass is not cut short by a command
  p_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(req_valid && req_ready) |=> busy);

endmodule

bind coef_avg_engine coef_avg_engine_chk #(.REG_AW(REG_AW), .REG_DW(REG_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .cmd_accum(cmd_accum), .cmd_wback(cmd_wback), .cmd_clear(cmd_clear),
  .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
  .req_addr(req_addr), .req_wdata(req_wdata), .wb_ok(wb_ok)
);

// File: tb/coef_avg_engine_tb.sv
module coef_avg_engine_tb;
  localparam int NC = 32, CW = 6, MR = 32, AW = 8, DW = 8;
  localparam int RCW = 6, IW = 5, SUM_MAX = 2047;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic core_sel = 1'b0, cmd_accum = 1'b0, cmd_wback = 1'b0, cmd_clear = 1'b0;
  logic [RCW-1:0] run_count = '0;
  logic busy, done, req_valid, req_wr;
  logic req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [DW-1:0] req_rdata = '0;
  logic [IW-1:0] dbg_idx = '0;
  logic [CW-1:0] dbg_avg;

  coef_avg_engine #(.NUM_COEF(NC), .COEF_W(CW), .MAX_RUNS(MR), .REG_AW(AW), .REG_DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_sel(core_sel), .run_count(run_count),
    .cmd_accum(cmd_accum), .cmd_wback(cmd_wback), .cmd_clear(cmd_clear),
    .busy(busy), .done(done), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .dbg_idx(dbg_idx), .dbg_avg(dbg_avg)
  );

  int checks = 0, fails = 0, cyc = 0;
  int mem [2][NC];
  int esum [NC];
  int r_sel = 0, r_addr = 0, r_mode = 0;
  int exp_mode = 0;   // 0 no traffic allowed, 1 accumulate, 2 write-back
  int exp_core = 0, exp_n = 0, exp_rc = 1;
  bit prev_stall = 0;
  logic prev_wr;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_wdata;

  function automatic int exp_avg(int s, int rc);
    int q;
    if (rc == 0) return 0;
    q = (s + rc / 2) / rc;
    return (q > 63) ? 63 : q;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic exp_txn(output bit w, output int a, output int d);
    int m, k, j, sel;
    sel = exp_core ? 32'h20 : 32'h10;
    w = 1; a = -1; d = 0;
    if (exp_mode == 1) begin
      if (exp_n == 0) begin a = 'h0E; d = sel; end
      else if (exp_n <= 4 * NC) begin
        m = exp_n - 1; k = m / 4; j = m % 4;
        case (j)
          0: begin a = 'h10; d = k + 1; end
          1: begin a = 'h12; d = 4; end
          2: begin w = 0; a = 'h11; end
          default: begin a = 'h12; d = 0; end
        endcase
      end else if (exp_n == 4 * NC + 1) begin a = 'h0E; d = 0; end
    end else if (exp_mode == 2) begin
      if (exp_n == 0) begin a = 'h0E; d = sel; end
      else if (exp_n <= 3 * NC) begin
        m = exp_n - 1; k = m / 3; j = m % 3;
        case (j)
          0: begin a = 'h12; d = 8; end
          1: begin a = 'h10; d = k + 1; end
          default: begin a = 'h11; d = exp_avg(esum[k], exp_rc); end
        endcase
      end else if (exp_n == 3 * NC + 1) begin a = 'h12; d = 0; end
      else if (exp_n == 3 * NC + 2) begin a = 'h0E; d = 0; end
    end
  endtask

  // Register model: decides ready and accepts requests between edges
  always @(negedge clk) begin
    bit w, rdy;
    int a, d, c;
    if (rst_n) begin
      if (prev_stall)
        chk(req_valid && req_wr == prev_wr && req_addr == prev_addr && req_wdata == prev_wdata,
            "R9 stalled request changed", int'(req_addr), int'(prev_addr));
      rdy = ($urandom_range(0, 99) < 65);
      req_ready = rdy;
      req_rdata = DW'($urandom);
      prev_stall = req_valid && !rdy;
      prev_wr = req_wr; prev_addr = req_addr; prev_wdata = req_wdata;
      if (req_valid && rdy) begin
        exp_txn(w, a, d);
        chk(req_wr == w && int'(req_addr) == a && (!w || int'(req_wdata) == d),
            (exp_mode == 1) ? "R2 accumulate request" :
            (exp_mode == 2) ? "R4 write-back request" : "R6/R8 unexpected request",
            int'(req_wr) * 65536 + int'(req_addr) * 256 + int'(req_wdata),
            int'(w) * 65536 + a * 256 + d);
        exp_n++;
        c = r_sel[5] ? 1 : 0;
        if (req_wr) begin
          case (req_addr)
            8'h0E: r_sel = int'(req_wdata);
            8'h10: r_addr = int'(req_wdata);
            8'h12: r_mode = int'(req_wdata);
            8'h11: if (r_mode == 8 && r_addr >= 1 && r_addr <= NC)
                     mem[c][r_addr-1] = int'(req_wdata) & 63;
            default: ;
          endcase
        end else if (req_addr == 8'h11 && r_mode == 4 && r_addr >= 1 && r_addr <= NC) begin
          req_rdata = {2'($urandom), 6'(mem[c][r_addr-1])};
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic issue(bit a, bit w, bit c, bit core, int rc);
    @(negedge clk);
    cmd_accum = a; cmd_wback = w; cmd_clear = c; core_sel = core; run_count = RCW'(rc);
    @(negedge clk);
    cmd_accum = 0; cmd_wback = 0; cmd_clear = 0;
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done && !busy, req, int'(busy), 0);
    @(negedge clk);
    chk(!done, "R10 done is one cycle", int'(done), 0);
  endtask

  task automatic expect_idle(string req);
    bit seen = 0;
    repeat (16) begin @(negedge clk); if (busy || done) seen = 1; end
    chk(!seen, req, int'(seen), 0);
  endtask

  task automatic clear_sums();
    issue(0, 0, 1, 0, int'(run_count));
    for (int k = 0; k < NC; k++) esum[k] = 0;
  endtask

  task automatic do_accum(bit core, int rc, bit also_wb, bit disturb);
    for (int k = 0; k < NC; k++) begin
      esum[k] = esum[k] + mem[core][k];
      if (esum[k] > SUM_MAX) esum[k] = SUM_MAX;
    end
    exp_mode = 1; exp_core = core; exp_n = 0;
    issue(1, also_wb, 0, core, rc);
    chk(busy, "R10 busy after accumulate command", int'(busy), 1);
    if (disturb) begin
      repeat (20) @(negedge clk);
      cmd_clear = 1; cmd_wback = 1; cmd_accum = 1; core_sel = !core;
      @(negedge clk);
      cmd_clear = 0; cmd_wback = 0; cmd_accum = 0; core_sel = core;
    end
    wait_done("R10 accumulate ends with done and busy low");
    chk(exp_n == 4 * NC + 2, "R2 accumulate request count", exp_n, 4 * NC + 2);
    exp_mode = 0;
  endtask

  task automatic do_wb(bit core, int rc);
    exp_mode = 2; exp_core = core; exp_rc = rc; exp_n = 0;
    issue(0, 1, 0, core, rc);
    chk(busy, "R10 busy after write-back command", int'(busy), 1);
    wait_done("R10 write-back ends with done and busy low");
    chk(exp_n == 3 * NC + 3, "R4 write-back request count", exp_n, 3 * NC + 3);
    exp_mode = 0;
    for (int k = 0; k < NC; k++)
      chk(mem[core][k] == exp_avg(esum[k], rc), "R4/R5 stored average", mem[core][k],
          exp_avg(esum[k], rc));
  endtask

  task automatic check_dbg(int rc, string req);
    run_count = RCW'(rc);
    for (int k = 0; k < NC; k++) begin
      @(negedge clk);
      dbg_idx = IW'(k);
      #1;
      chk(int'(dbg_avg) == exp_avg(esum[k], rc), req, int'(dbg_avg), exp_avg(esum[k], rc));
    end
  endtask

  initial begin
    void'($urandom(32'hC0EF5EED));
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < NC; k++) mem[c][k] = 0;
    for (int k = 0; k < NC; k++) esum[k] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !req_valid, "R1 reset outputs", int'({busy, done, req_valid}), 0);
    check_dbg(3, "R1 sums zero after reset");
    rst_n = 1'b1;

    // R6: write-back before any accumulate
    issue(0, 1, 0, 0, 3);
    expect_idle("R6 write-back refused without data");

    // Random accumulate passes on core I, then write-back
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < NC; k++) mem[0][k] = $urandom_range(0, 63);
      do_accum(0, 3, 0, 0);
    end
    check_dbg(3, "R11 debug average, three runs");
    check_dbg(5, "R11 debug average follows run_count");
    do_wb(0, 3);

    // R6: zero run count refused
    issue(0, 1, 0, 0, 0);
    expect_idle("R6 write-back refused with run_count 0");

    // R12: clear and accumulate together -> clear only
    issue(1, 0, 1, 0, 3);
    for (int k = 0; k < NC; k++) esum[k] = 0;
    expect_idle("R12 clear wins over accumulate");
    check_dbg(3, "R7 sums zero after clear");
    issue(0, 1, 0, 0, 3);
    expect_idle("R7 clear withdraws write-back permission");

    // R12: accumulate and write-back together -> accumulate
    for (int k = 0; k < NC; k++) mem[1][k] = $urandom_range(0, 63);
    do_accum(1, 2, 1, 0);

    // R8: commands during a pass are ignored
    for (int k = 0; k < NC; k++) mem[1][k] = $urandom_range(0, 63);
    do_accum(1, 2, 0, 1);
    check_dbg(2, "R8 sums kept across commands during a pass");

    // R5: rounding half up
    clear_sums();
    for (int k = 0; k < NC; k++) mem[1][k] = k;
    do_accum(1, 2, 0, 0);
    for (int k = 0; k < NC; k++) mem[1][k] = k + 1;
    do_accum(1, 2, 0, 0);
    for (int k = 0; k < NC; k++)
      chk(exp_avg(esum[k], 2) == k + 1, "R5 bench rounding model", exp_avg(esum[k], 2), k + 1);
    do_wb(1, 2);

    // R3/R5: sum and average saturation
    clear_sums();
    for (int p = 0; p < 40; p++) begin
      for (int k = 0; k < NC; k++) mem[1][k] = 63;
      do_accum(1, 63, 0, 0);
    end
    check_dbg(63, "R3 saturated sum divided by 63");
    check_dbg(1, "R5 average clamps to 63");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule